// File: doc/BRIEF.md
# Microcode Sequencer with Named Link Registers

This block is the program-counter stage of a small microcode engine. In every cycle it takes the control class of the instruction at the current fetch address, together with a jump target, a condition bit and two link-register selectors, all already decoded. It then settles which address is fetched next. The supported classes are: advance, jump, conditional jump, call, return and sleep. Instruction storage, decode and the ALU live elsewhere.

Subroutine linkage uses a small bank of PC-wide link registers instead of a stack. A call names the register that takes the return address. A return names two registers: one receives the current return address and the other supplies the jump address. Two routines can therefore hand control back and forth without any stack depth. A sleep instruction parks the engine with its PC frozen until an external event arrives, and fetch then resumes at the following instruction.

Top module: `useq_top`

## Requirements
- R1: While `rst` is high at a clock edge, the PC (`fetch_pc_o`) becomes 0, `sleeping_o` becomes 0 and every link register becomes 0.
- R2: Class code 0 (advance) makes the next PC equal to PC+1, wrapping modulo 2^PC_W (the PC after all ones is 0).
- R3: Class code 1 (jump) loads `target_i` into the PC.
- R4: Class code 2 (conditional jump) loads `target_i` when `cond_i` is 1 and gives PC+1 when `cond_i` is 0.
- R5: Class code 3 (call) writes PC+1 into the link register chosen by `link_wr_sel_i` and loads `target_i` into the PC.
- R6: Class code 4 (return) loads the PC from the link register chosen by `link_rd_sel_i` and writes PC+1 into the link register chosen by `link_wr_sel_i`, both in the same cycle.
- R7: When a return names the same register for both selectors, the jump uses that register's value from before the instruction, and the register then holds the new PC+1.
- R8: Class code 5 (sleep), when not sleeping, makes `sleeping_o` 1 in the next cycle with the PC unchanged. This happens even if `event_i` is high in the same cycle.
- R9: While `sleeping_o` is 1 and `event_i` is 0, the PC and `sleeping_o` hold. All class, target, condition and selector inputs are ignored, and no link register is written.
- R10: When `event_i` is 1 while `sleeping_o` is 1, the next cycle has `sleeping_o` 0 and the PC equal to the held PC+1.
- R11: Class codes 6 and 7 behave as advance (PC+1, no link write).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ctl_i | input | 3 | Control class of the current instruction (codes as in R2 to R11) |
| target_i | input | PC_W | Jump or call destination |
| cond_i | input | 1 | Condition result for conditional jump |
| link_wr_sel_i | input | $clog2(N_LINK) | Link register written by call or return |
| link_rd_sel_i | input | $clog2(N_LINK) | Link register read by return |
| event_i | input | 1 | Wake-up event for a sleeping engine |
| fetch_pc_o | output | PC_W | Address of the instruction to fetch (the PC) |
| sleeping_o | output | 1 | High while the engine is asleep |

## Verification
The bench builds the block with PC_W = 6 and the default four link registers. With these values every jump and conditional-jump target can be swept, and an advance run crosses the wrap from 63 to 0. Every ordered pair of write and read selectors for a return is covered, including the four same-register cases. Sleep is exercised with stays of several lengths while a conflicting call is held on the inputs, and the untouched link register is then read back through a return.

// File: rtl/useq_pkg.sv
package useq_pkg;

    // Control class codes presented by the decoder; 6 and 7 act as advance
    typedef enum logic [2:0] {
        CTL_NEXT  = 3'd0,
        CTL_JUMP  = 3'd1,
        CTL_CJMP  = 3'd2,
        CTL_CALL  = 3'd3,
        CTL_RET   = 3'd4,
        CTL_SLEEP = 3'd5
    } ctl_e;

    // Where the next PC comes from
    typedef enum logic [1:0] {
        SRC_INC  = 2'd0,
        SRC_TGT  = 2'd1,
        SRC_LINK = 2'd2,
        SRC_HOLD = 2'd3
    } pc_src_e;

    typedef enum logic {
        ST_RUN = 1'b0,
        ST_NAP = 1'b1
    } nap_state_e;

    // Per-instruction sequencing decision
    typedef struct packed {
        pc_src_e src;
        logic    link_we;
        logic    nap;
    } step_t;

    function automatic step_t classify(input logic [2:0] code, input logic cond);
        step_t s;
        s.src     = SRC_INC;
        s.link_we = 1'b0;
        s.nap     = 1'b0;
        case (code)
            CTL_JUMP: s.src = SRC_TGT;
            CTL_CJMP: if (cond) s.src = SRC_TGT;
            CTL_CALL: begin
                s.src     = SRC_TGT;
                s.link_we = 1'b1;
            end
            CTL_RET: begin
                s.src     = SRC_LINK;
                s.link_we = 1'b1;
            end
            CTL_SLEEP: begin
                s.src = SRC_HOLD;
                s.nap = 1'b1;
            end
            default: ;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/useq_sleepctl.sv
module useq_sleepctl
    import useq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic enter,
    input  logic wake_evt,
    output logic sleeping,
    output logic resume
);

    nap_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_RUN: if (enter)    state_d = ST_NAP;
            ST_NAP: if (wake_evt) state_d = ST_RUN;
            default: state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_RUN;
        else     state_q <= state_d;
    end

    assign sleeping = (state_q == ST_NAP);
    assign resume   = sleeping & wake_evt;

endmodule

// File: rtl/useq_linkbank.sv
module useq_linkbank #(
    parameter int W     = 12,
    parameter int N     = 4,
    localparam int SEL_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [SEL_W-1:0] wsel,
    input  logic [W-1:0]     wdata,
    input  logic [SEL_W-1:0] rsel,
    output logic [W-1:0]     rdata
);

    logic [W-1:0] bank [N];

    for (genvar g = 0; g < N; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                bank[g] <= '0;
            else if (we && (wsel == SEL_W'(g)))
                bank[g] <= wdata;
        end
    end

    // Read is combinational, so a return sees the pre-write value
    assign rdata = bank[rsel];

endmodule

// File: rtl/useq_nextpc.sv
module useq_nextpc
    import useq_pkg::*;
#(
    parameter int W = 12
) (
    input  logic [W-1:0] pc,
    input  logic [W-1:0] target,
    input  logic [W-1:0] link_data,
    input  pc_src_e      src,
    output logic [W-1:0] ret_pc,
    output logic [W-1:0] nxt
);

    assign ret_pc = pc + 1'b1;

    always_comb begin
        case (src)
            SRC_TGT:  nxt = target;
            SRC_LINK: nxt = link_data;
            SRC_HOLD: nxt = pc;
            default:  nxt = ret_pc;
        endcase
    end

endmodule

// File: rtl/useq_top.sv
module useq_top
    import useq_pkg::*;
#(
    parameter int PC_W   = 12,
    parameter int N_LINK = 4,
    localparam int SEL_W = $clog2(N_LINK)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [2:0]       ctl_i,
    input  logic [PC_W-1:0]  target_i,
    input  logic             cond_i,
    input  logic [SEL_W-1:0] link_wr_sel_i,
    input  logic [SEL_W-1:0] link_rd_sel_i,
    input  logic             event_i,
    output logic [PC_W-1:0]  fetch_pc_o,
    output logic             sleeping_o
);

    logic [PC_W-1:0] pc_q;
    logic [PC_W-1:0] pc_d;
    logic [PC_W-1:0] ret_pc;
    logic [PC_W-1:0] link_rd_data;
    step_t           dec;
    pc_src_e         src_eff;
    logic            sleeping;
    logic            resume;
    logic            link_we_eff;
    logic            enter_nap;

    assign dec = classify(ctl_i, cond_i);

    // While asleep the instruction inputs are dropped entirely
    assign link_we_eff = dec.link_we & ~sleeping;
    assign enter_nap   = dec.nap & ~sleeping;

    always_comb begin
        if (sleeping)
            src_eff = resume ? SRC_INC : SRC_HOLD;
        else
            src_eff = dec.src;
    end

    useq_sleepctl u_sleep (
        .clk      (clk),
        .rst      (rst),
        .enter    (enter_nap),
        .wake_evt (event_i),
        .sleeping (sleeping),
        .resume   (resume)
    );

    useq_linkbank #(.W(PC_W), .N(N_LINK)) u_links (
        .clk   (clk),
        .rst   (rst),
        .we    (link_we_eff),
        .wsel  (link_wr_sel_i),
        .wdata (ret_pc),
        .rsel  (link_rd_sel_i),
        .rdata (link_rd_data)
    );

    useq_nextpc #(.W(PC_W)) u_next (
        .pc        (pc_q),
        .target    (target_i),
        .link_data (link_rd_data),
        .src       (src_eff),
        .ret_pc    (ret_pc),
        .nxt       (pc_d)
    );

    always_ff @(posedge clk) begin
        if (rst) pc_q <= '0;
        else     pc_q <= pc_d;
    end

    assign fetch_pc_o = pc_q;
    assign sleeping_o = sleeping;

endmodule

// File: rtl/useq_chk.sv
module useq_chk #(
    parameter int PC_W = 12
) (
    input logic            clk,
    input logic            rst,
    input logic [2:0]      ctl,
    input logic [PC_W-1:0] target,
    input logic            cond,
    input logic            evt,
    input logic [PC_W-1:0] pc,
    input logic            sleeping,
    input logic [PC_W-1:0] link_rd
);

    logic awake;
    assign awake = ~sleeping;

    // R2
    advance_inc_chk: assert property (@(posedge clk) disable iff (rst)
        (awake && ctl == 3'd0) |=> (pc == $past(pc) + 1'b1));

    // R3
    jump_load_chk: assert property (@(posedge clk) disable iff (rst)
        (awake && ctl == 3'd1) |=> (pc == $past(target)));

    // R4
    cjump_sel_chk: assert property (@(posedge clk) disable iff (rst)
        (awake && ctl == 3'd2) |=>
            (pc == ($past(cond) ? $past(target) : $past(pc) + 1'b1)));

    // R5
    call_target_chk: assert property (@(posedge clk) disable iff (rst)
        (awake && ctl == 3'd3) |=> (pc == $past(target)));

    // R6
    ret_link_chk: assert property (@(posedge clk) disable iff (rst)
        (awake && ctl == 3'd4) |=> (pc == $past(link_rd)));

    // R8
    sleep_enter_chk: assert property (@(posedge clk) disable iff (rst)
        (awake && ctl == 3'd5) |=> (sleeping && $stable(pc)));

    // R9
    sleep_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (sleeping && !evt) |=> (sleeping && $stable(pc)));

    // R10
    wake_resume_chk: assert property (@(posedge clk) disable iff (rst)
        (sleeping && evt) |=> (!sleeping && pc == $past(pc) + 1'b1));

    // R11
    spare_code_chk: assert property (@(posedge clk) disable iff (rst)
        (awake && ctl[2:1] == 2'b11) |=> (pc == $past(pc) + 1'b1));

endmodule

bind useq_top useq_chk #(.PC_W(PC_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .ctl      (ctl_i),
    .target   (target_i),
    .cond     (cond_i),
    .evt      (event_i),
    .pc       (fetch_pc_o),
    .sleeping (sleeping_o),
    .link_rd  (link_rd_data)
);

// File: tb/test_useq_top.sv
`timescale 1ns/1ps
module test_useq_top;

    localparam int PW = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [2:0]    ctl = '0;
    logic [PW-1:0] tgt = '0;
    logic          cond = 1'b0;
    logic [1:0]    wsel = '0;
    logic [1:0]    rsel = '0;
    logic          ev = 1'b0;
    logic [PW-1:0] pc;
    logic          slp;

    int checks = 0;
    int errors = 0;

    // Bench-side expectation state
    logic [PW-1:0] m_pc;
    logic          m_sl;
    logic [PW-1:0] m_lr [4];

    always #2.5 clk = ~clk;

    useq_top #(.PC_W(PW), .N_LINK(4)) i_useq_top (
        .clk           (clk),
        .rst           (rst),
        .ctl_i         (ctl),
        .target_i      (tgt),
        .cond_i        (cond),
        .link_wr_sel_i (wsel),
        .link_rd_sel_i (rsel),
        .event_i       (ev),
        .fetch_pc_o    (pc),
        .sleeping_o    (slp)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Drive one instruction at a falling edge, predict, sample at the next falling edge
    task automatic step(input logic [2:0] c, input logic [PW-1:0] t, input logic cd,
                        input logic [1:0] w, input logic [1:0] r, input logic ev_in,
                        input string tag);
        logic [PW-1:0] np;
        ctl = c; tgt = t; cond = cd; wsel = w; rsel = r; ev = ev_in;
        if (m_sl) begin
            if (ev_in) begin
                m_pc = m_pc + 1'b1;
                m_sl = 1'b0;
            end
        end else begin
            case (c)
                3'd1: m_pc = t;
                3'd2: m_pc = cd ? t : m_pc + 1'b1;
                3'd3: begin
                    m_lr[w] = m_pc + 1'b1;
                    m_pc = t;
                end
                3'd4: begin
                    np = m_lr[r];
                    m_lr[w] = m_pc + 1'b1;
                    m_pc = np;
                end
                3'd5: m_sl = 1'b1;
                default: m_pc = m_pc + 1'b1;
            endcase
        end
        @(posedge clk);
        @(negedge clk);
        chk({tag, " pc"}, int'(pc), int'(m_pc));
        chk({tag, " sleeping"}, int'(slp), int'(m_sl));
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        m_pc = '0;
        m_sl = 1'b0;
        for (int i = 0; i < 4; i++) m_lr[i] = '0;

        // R1: reset state
        @(negedge clk); @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1 pc", int'(pc), 0);
        chk("R1 sleeping", int'(slp), 0);
        // R1: each link register reads back zero through a same-slot return
        for (int k = 0; k < 4; k++) begin
            step(3'd1, 6'(17 + k), 1'b0, 2'd0, 2'd0, 1'b0, "R3");
            step(3'd4, '0, 1'b0, 2'(k), 2'(k), 1'b0, "R1");
        end

        // R2: advance across the wrap from 63 to 0
        step(3'd1, 6'd58, 1'b0, 2'd0, 2'd0, 1'b0, "R3");
        for (int i = 0; i < 10; i++)
            step(3'd0, 6'(i * 7), 1'b1, 2'd0, 2'd0, 1'b0, "R2");

        // R3: every jump target
        for (int t = 0; t < 64; t++)
            step(3'd1, 6'(63 - t), 1'b0, 2'd0, 2'd0, 1'b0, "R3");

        // R4: conditional jump, condition alternating
        for (int t = 0; t < 64; t++)
            step(3'd2, 6'(t * 5 + 3), t[0], 2'd0, 2'd0, 1'b0, "R4");

        // R5: calls into every slot from distinct sites
        for (int w = 0; w < 4; w++) begin
            step(3'd1, 6'(10 + 3 * w), 1'b0, 2'd0, 2'd0, 1'b0, "R3");
            step(3'd3, 6'(40 + w), 1'b0, 2'(w), 2'd0, 1'b0, "R5");
        end

        // R6 / R7: every ordered selector pair, same-slot cases included
        for (int a = 0; a < 4; a++)
            for (int b = 0; b < 4; b++)
                step(3'd4, 6'd0, 1'b1, 2'(a), 2'(b), 1'b0, (a == b) ? "R7" : "R6");

        // R8 / R9 / R10: sleeps of several lengths with a call held on the inputs
        for (int d = 0; d < 6; d++) begin
            step(3'd1, 6'(20 + d), 1'b0, 2'd0, 2'd0, 1'b0, "R3");
            step(3'd3, 6'd50, 1'b0, 2'd1, 2'd0, 1'b0, "R5");
            // R8: event high in the sleep cycle itself does not stop the entry
            step(3'd5, 6'd0, 1'b0, 2'd0, 2'd0, (d == 2), "R8");
            for (int i = 0; i < d; i++)
                step(3'd3, 6'd55, 1'b1, 2'd1, 2'd0, 1'b0, "R9");
            step(3'd3, 6'd55, 1'b1, 2'd1, 2'd0, 1'b1, "R10");
            // R9: slot 1 must still hold the value from before the sleep
            step(3'd4, 6'd0, 1'b0, 2'd2, 2'd1, 1'b0, "R9");
        end

        // R11: spare codes act as advance, with no link write
        step(3'd1, 6'd30, 1'b0, 2'd0, 2'd0, 1'b0, "R3");
        step(3'd6, 6'd9, 1'b1, 2'd3, 2'd0, 1'b0, "R11");
        step(3'd7, 6'd9, 1'b1, 2'd3, 2'd0, 1'b0, "R11");
        step(3'd4, 6'd0, 1'b0, 2'd0, 2'd3, 1'b0, "R11");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule